// File: doc/BRIEF.md
# Adaptive Pulse-Skipping Overcurrent Limiter

This block stands between the pulse-width modulator and the gate command of a power switch and enforces cycle-by-cycle current limiting. Each switching cycle begins with a one-clock cycle-start tick. On that tick a new on-time may begin. For a fixed number of clocks after it starts, the overcurrent comparator is ignored, because switching noise would give false readings. When this blanking window closes, the comparator is sampled. An overload at that sample, or at any later clock of the same on-time, ends the pulse at once. It also raises an adaptive skip level, and the switch then sits out that many following cycles. A clean sample lowers the level by one.

Under a sustained short the level climbs to its ceiling of seven. From then on only one switching cycle in eight carries a pulse, which keeps the average current near the limit. The analog current sensing and the comparator threshold are outside this block. Only the comparator's digital flag comes in.

Top module: `ocp_pulse_skipper`

## Requirements
- R1: The gate output is high only while `en` and `pwm_req` are both high and an on-time is in progress. An on-time starts only at a cycle-start tick that is not skipped and sees `pwm_req` high. It ends when `pwm_req` goes low.
- R2: During the first BLANK_CYC clocks of an on-time, `oc_flag` has no effect. Over those clocks the gate follows `pwm_req`, and the skip level does not change.
- R3: If `oc_flag` is high in the last blanking clock, the gate goes low from the next clock onward and the skip level rises by one.
- R4: After an overload, the next N cycle-start ticks are skipped, where N is the raised skip level. In a skipped cycle the gate stays low whatever `pwm_req` does, `oc_flag` is not sampled, and the skip level is held.
- R5: If `oc_flag` is low in the last blanking clock, the skip level falls by one. It never goes below zero.
- R6: The skip level saturates at MAX_SKIP (7 by default). Under a persistent overload, exactly two of any sixteen consecutive switching cycles then carry a pulse.
- R7: If `oc_flag` goes high after blanking while the on-time is still running, the pulse ends on the next clock. This counts as an overload: the level rises by one and skips follow as in R4.
- R8: Reset, or a low `en`, forces the gate low at once. From the next clock the skip level is zero and no skips are pending, so the first tick after re-enable is not skipped.
- R9: If `pwm_req` falls before blanking ends, no sample is taken and the skip level is unchanged.
- R10: If `pwm_req` stays high across a cycle-start tick, the on-time restarts at that tick with a fresh blanking window and a fresh sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low clears the skip state and holds the gate low |
| cycle_tick | input | 1 | One-clock pulse marking the start of a switching cycle |
| pwm_req | input | 1 | Gate request from the modulator |
| oc_flag | input | 1 | Overcurrent comparator flag |
| gate | output | 1 | Power-switch gate command |
| skip_lvl | output | $clog2(MAX_SKIP+1) | Current adaptive skip level |

## Verification
The bench builds the block with BLANK_CYC = 4 and MAX_SKIP = 7, and drives a 16-clock switching cycle. With the short blanking window, a pulse can end before blanking, at the sample clock, or several clocks later, all inside one cycle. It can also run through the whole cycle and into the next tick. With the default ceiling of seven, about forty overloaded cycles carry the level all the way to saturation. A sixteen-cycle window at saturation then shows the one-in-eight pulse pattern.

// File: rtl/ocp_limiter_pkg.sv
`timescale 1ns/1ps
package ocp_limiter_pkg;
    // Where the current switching cycle is in its on-time
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // no on-time in progress
        PH_BLANK = 2'd1,   // on-time, comparator masked
        PH_WATCH = 2'd2    // on-time, comparator live
    } phase_e;
endpackage

// File: rtl/ocp_blank_timer.sv
`timescale 1ns/1ps
module ocp_blank_timer #(
    parameter int BLANK_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(BLANK_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(BLANK_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign done = (tmr_q.cnt == LAST);

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.cnt = '0;
        end else if (run && !done) begin
            tmr_d.cnt = tmr_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/ocp_skip_level.sv
`timescale 1ns/1ps
module ocp_skip_level #(
    parameter int MAX_SKIP = 7
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr,
    input  logic                              up,
    input  logic                              dn,
    output logic [$clog2(MAX_SKIP+1)-1:0]     lvl,
    output logic [$clog2(MAX_SKIP+1)-1:0]     lvl_up
);
    localparam int LW = $clog2(MAX_SKIP + 1);
    localparam logic [LW-1:0] CEIL = LW'(MAX_SKIP);

    typedef struct packed {
        logic [LW-1:0] lvl;
    } lvl_t;

    lvl_t lv_d, lv_q;

    assign lvl    = lv_q.lvl;
    assign lvl_up = (lv_q.lvl == CEIL) ? CEIL : lv_q.lvl + LW'(1);

    always_comb begin
        lv_d = lv_q;
        if (clr) begin
            lv_d.lvl = '0;
        end else if (up) begin
            lv_d.lvl = lvl_up;
        end else if (dn && lv_q.lvl != '0) begin
            lv_d.lvl = lv_q.lvl - LW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lv_q <= '0;
        else        lv_q <= lv_d;
    end
endmodule

// File: rtl/ocp_skip_window.sv
`timescale 1ns/1ps
module ocp_skip_window #(
    parameter int MAX_SKIP = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          load,
    input  logic [$clog2(MAX_SKIP+1)-1:0] load_val,
    input  logic                          tick,
    output logic                          busy
);
    localparam int LW = $clog2(MAX_SKIP + 1);

    typedef struct packed {
        logic [LW-1:0] left;
    } win_t;

    win_t win_d, win_q;

    assign busy = (win_q.left != '0);

    always_comb begin
        win_d = win_q;
        if (clr) begin
            win_d.left = '0;
        end else if (load) begin
            win_d.left = load_val;
        end else if (tick && busy) begin
            win_d.left = win_q.left - LW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end
endmodule

// File: rtl/ocp_pulse_skipper.sv
`timescale 1ns/1ps
module ocp_pulse_skipper #(
    parameter int BLANK_CYC = 50,
    parameter int MAX_SKIP  = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en,
    input  logic                          cycle_tick,
    input  logic                          pwm_req,
    input  logic                          oc_flag,
    output logic                          gate,
    output logic [$clog2(MAX_SKIP+1)-1:0] skip_lvl
);
    import ocp_limiter_pkg::*;

    localparam int LW = $clog2(MAX_SKIP + 1);

    typedef struct packed {
        phase_e phase;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          blank_done;
    logic          win_busy;
    logic [LW-1:0] lvl_up;
    logic          blank_start;
    logic          in_blank;
    logic          sample;
    logic          late_ovl;
    logic          overload;
    logic          clean;
    logic          tick_en;

    // Cycle-level decisions
    assign tick_en     = en && cycle_tick;
    assign blank_start = tick_en && !win_busy && pwm_req;
    assign in_blank    = (ctl_q.phase == PH_BLANK);
    assign sample      = en && !cycle_tick && in_blank && pwm_req && blank_done;
    assign late_ovl    = en && !cycle_tick && (ctl_q.phase == PH_WATCH)
                         && pwm_req && oc_flag;
    assign overload    = (sample && oc_flag) || late_ovl;
    assign clean       = sample && !oc_flag;

    assign gate = en && pwm_req && (ctl_q.phase != PH_IDLE);

    ocp_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .start (blank_start),
        .run   (in_blank),
        .done  (blank_done)
    );

    ocp_skip_level #(.MAX_SKIP(MAX_SKIP)) u_level (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!en),
        .up     (overload),
        .dn     (clean),
        .lvl    (skip_lvl),
        .lvl_up (lvl_up)
    );

    ocp_skip_window #(.MAX_SKIP(MAX_SKIP)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!en),
        .load     (overload),
        .load_val (lvl_up),
        .tick     (tick_en),
        .busy     (win_busy)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (!en) begin
            ctl_d.phase = PH_IDLE;
        end else if (cycle_tick) begin
            ctl_d.phase = blank_start ? PH_BLANK : PH_IDLE;
        end else begin
            unique case (ctl_q.phase)
                PH_BLANK: begin
                    if (!pwm_req)        ctl_d.phase = PH_IDLE;
                    else if (blank_done) ctl_d.phase = oc_flag ? PH_IDLE : PH_WATCH;
                end
                PH_WATCH: begin
                    if (!pwm_req || oc_flag) ctl_d.phase = PH_IDLE;
                end
                default: ctl_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{phase: PH_IDLE};
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/ocp_pulse_skipper_chk.sv
`timescale 1ns/1ps
module ocp_pulse_skipper_chk #(
    parameter int MAX_SKIP = 7
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          en,
    input logic                          pwm_req,
    input logic                          gate,
    input logic                          win_busy,
    input logic [$clog2(MAX_SKIP+1)-1:0] skip_lvl
);
    AST_GATE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (pwm_req && en)); // R1

    AST_SKIP_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        win_busy |-> !gate); // R4

    AST_LEVEL_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        int'(skip_lvl) <= MAX_SKIP); // R6

    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && en) |-> (int'(skip_lvl) == int'($past(skip_lvl))
                               || int'(skip_lvl) == int'($past(skip_lvl)) + 1
                               || int'(skip_lvl) + 1 == int'($past(skip_lvl)))); // R5

    AST_RISE_ENDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_lvl > $past(skip_lvl)) |-> !gate); // R3

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (skip_lvl == '0 && !win_busy)); // R8
endmodule

bind ocp_pulse_skipper ocp_pulse_skipper_chk #(.MAX_SKIP(MAX_SKIP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .pwm_req  (pwm_req),
    .gate     (gate),
    .win_busy (win_busy),
    .skip_lvl (skip_lvl)
);

// File: tb/ocp_pulse_skipper_bench.sv
`timescale 1ns/1ps
module ocp_pulse_skipper_bench;
    localparam int B   = 4;
    localparam int MS  = 7;
    localparam int PER = 16;
    localparam int NEV = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       cycle_tick = 1'b0;
    logic       pwm_req = 1'b0;
    logic       oc_flag = 1'b0;
    logic       gate;
    logic [2:0] skip_lvl;

    int checks = 0;
    int fails  = 0;
    int lvl_e  = 0;
    int left_e = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ocp_pulse_skipper #(.BLANK_CYC(B), .MAX_SKIP(MS)) u_ocp_pulse_skipper (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .cycle_tick (cycle_tick),
        .pwm_req    (pwm_req),
        .oc_flag    (oc_flag),
        .gate       (gate),
        .skip_lvl   (skip_lvl)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One switching cycle: tick in clock 0, pwm_req high in clocks 0..on_len,
    // oc_flag high in clocks oc_s..oc_e. Counts gate-high clocks 1..PER-1.
    task automatic cyc(input int on_len, input int oc_s, input int oc_e,
                       input string tag, output int g);
        int eg;
        int m;
        g = 0;
        for (int k = 0; k < PER; k++) begin
            @(negedge clk);
            cycle_tick = (k == 0);
            pwm_req    = (k <= on_len);
            oc_flag    = (k >= oc_s && k <= oc_e);
            #1;
            if (k > 0 && gate) g++;
        end
        @(posedge clk);
        #1;
        if (left_e > 0) begin
            left_e--;
            eg = 0;
        end else if (on_len < B) begin
            eg = on_len;
        end else if (oc_s <= B && oc_e >= B) begin
            eg = B;
            lvl_e = (lvl_e < MS) ? lvl_e + 1 : MS;
            left_e = lvl_e;
        end else begin
            lvl_e = (lvl_e > 0) ? lvl_e - 1 : 0;
            m = (oc_s > B + 1) ? oc_s : B + 1;
            if (m <= oc_e && m <= on_len && m <= PER - 1) begin
                eg = m;
                lvl_e = (lvl_e < MS) ? lvl_e + 1 : MS;
                left_e = lvl_e;
            end else begin
                eg = (on_len < PER - 1) ? on_len : PER - 1;
            end
        end
        check(g == eg, {tag, " gate clocks"}, g, eg);
        check(int'(skip_lvl) == lvl_e, {tag, " skip level"}, int'(skip_lvl), lvl_e);
    endtask

    task automatic t_reset();
        pwm_req = 1'b1;
        en = 1'b1;
        #1;
        check(gate == 1'b0, "R8 gate in reset", int'(gate), 0);
        check(skip_lvl == 3'd0, "R8 level in reset", int'(skip_lvl), 0);
        @(negedge clk);
        rst_n = 1'b1;
        pwm_req = 1'b0;
        #1;
        check(gate == 1'b0, "R1 gate idle without tick", int'(gate), 0);
    endtask

    task automatic t_clean();
        int g;
        cyc(6, NEV, -1, "R1 clean pulse", g);
        cyc(10, NEV, -1, "R5 clean floor", g);
    endtask

    task automatic t_blank_ignore();
        int g;
        cyc(8, 1, 3, "R2 flag inside blanking", g);
        cyc(2, 1, 15, "R9 early fall", g);
    endtask

    task automatic t_overload_skip();
        int g;
        cyc(8, 1, 15, "R3 first overload", g);
        cyc(8, 0, 15, "R4 skipped cycle", g);
        cyc(8, 2, 15, "R3 second overload", g);
        cyc(12, 0, 15, "R4 skip one of two", g);
        cyc(12, 0, 15, "R4 skip two of two", g);
        cyc(2, 1, 15, "R9 fall with level held", g);
        cyc(6, NEV, -1, "R5 clean step down", g);
        cyc(6, NEV, -1, "R5 clean to zero", g);
    endtask

    task automatic t_late();
        int g;
        cyc(10, 7, 15, "R7 late overcurrent", g);
        cyc(10, NEV, -1, "R7 skip after late overload", g);
        cyc(6, NEV, -1, "R5 recover after late", g);
    endtask

    task automatic t_full_duty();
        int g;
        cyc(15, NEV, -1, "R10 full duty first", g);
        cyc(15, NEV, -1, "R10 full duty restart", g);
        cyc(15, B, B, "R10 overload on restarted pulse", g);
        cyc(6, NEV, -1, "R10 skip after restart overload", g);
        cyc(6, NEV, -1, "R5 level down after full duty", g);
    endtask

    task automatic t_saturate();
        int g;
        int pulses;
        for (int i = 0; i < 40; i++) cyc(8, 1, 15, "R6 climb", g);
        check(int'(skip_lvl) == MS, "R6 level at ceiling", int'(skip_lvl), MS);
        pulses = 0;
        for (int i = 0; i < 16; i++) begin
            cyc(8, 1, 15, "R6 saturated", g);
            if (g > 0) pulses++;
        end
        check(pulses == 2, "R6 pulses in sixteen cycles", pulses, 2);
    endtask

    task automatic t_disable();
        int g;
        cyc(8, 1, 15, "R8 overload before disable", g);
        @(negedge clk);
        en = 1'b0;
        pwm_req = 1'b1;
        cycle_tick = 1'b1;
        #1;
        check(gate == 1'b0, "R8 gate low when disabled", int'(gate), 0);
        for (int i = 0; i < 4; i++) @(negedge clk);
        #1;
        check(skip_lvl == 3'd0, "R8 level cleared by disable", int'(skip_lvl), 0);
        check(gate == 1'b0, "R8 gate still low", int'(gate), 0);
        lvl_e = 0;
        left_e = 0;
        cycle_tick = 1'b0;
        pwm_req = 1'b0;
        en = 1'b1;
        cyc(6, NEV, -1, "R8 first cycle after enable", g);
    endtask

    initial begin
        t_reset();
        t_clean();
        t_blank_ignore();
        t_overload_skip();
        t_late();
        t_full_duty();
        t_saturate();
        t_disable();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule